// File: doc/BRIEF.md
# Programmable Video Line Delay

This block delays a stream of pixel words by a programmable number of enabled clock cycles. It is typically used to line up a pixel with the pixel in the same column of the next scan line. The delay is built from two storage banks of `DEPTH` words by `W` bits. Each delay lane keeps one address counter. On every enabled clock the lane reads the word stored at the current address and writes the new input word to that same address. The counter wraps after the programmed length, so each word comes back out exactly that many enabled clocks after it went in. The block accepts one word per clock.

A two-bit arrangement input sets how the two banks are used:
- **Code 0 (dual):** two independent 12-bit lanes, each with its own length and its own enable.
- **Code 1 (triple):** three 8-bit lanes packed across both banks. The three lanes share one length and one enable.
- **Code 2 (deep):** both banks are chained into a single 12-bit lane of twice the depth. The top address bit picks the bank.
- **Code 3:** reserved, and behaves like code 0.

The arrangement is decoded by a `unique case` over an enumerated type with four named values: `ARR_DUAL`, `ARR_TRIPLE`, `ARR_DEEP` and `ARR_DUAL_ALT`. It is not a sequencing machine. The arrangement decode just selects which counter, enable and data path feeds each bank. Lengths are loaded from a shared length bus under a per-lane load strobe.

Top module: `lb_line_delay`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, both data outputs read 0.
- R2: In arrangement 0 (mode = 2'b00), a word written on lane A is delayed by N_A enabled clocks. Lane A takes wr_en[0], din_a and dout_a. N_A is taken from len_in[11:0] when len_load[0] is pulsed. The word appears on dout_a just after the N_A-th enabled edge that follows its own write.
- R3: In arrangement 0, lane B (wr_en[1], din_b, dout_b) has its own length N_B. N_B is loaded from len_in[11:0] on len_load[1]. The B delay does not depend on lane A's length or on lane A's enable pattern.
- R4: A length value of 1 gives a delay of one enabled clock. A length value of 0 gives the full depth: 4096 in arrangements 0 and 1, and 8192 in arrangement 2.
- R5: On a clock where a lane's write enable is low, that lane's address counter holds and its output bits hold their previous values.
- R6: In arrangement 1 (mode = 2'b01), the 24 bits {din_b, din_a} carry three 8-bit lanes:
  - lane 0 is din_a[7:0];
  - lane 1 is {din_b[3:0], din_a[11:8]};
  - lane 2 is din_b[11:4].
  The outputs use the same positions on {dout_b, dout_a}. All three lanes use wr_en[0], len_load[0] and one 12-bit length. wr_en[1] and len_load[1] are ignored.
- R7: In arrangement 2 (mode = 2'b10), din_a feeds a single lane whose output is dout_a. The length is len_in[12:0], which allows delays up to 8192. dout_b reads 0.
- R8: A load pulse clears that lane's address counter. If the same lane's write enable is high in the same cycle, the load wins: that cycle's word is not stored and the lane's output holds. Outputs are undefined until N words have been written after a load, and defined from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one word per lane per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Arrangement: 0 dual, 1 triple 8-bit, 2 deep, 3 as dual |
| len_in | input | $clog2(DEPTH)+1 | Length value captured by a load strobe |
| len_load | input | 2 | Length load strobe per lane (bit 0 lane A, bit 1 lane B) |
| wr_en | input | 2 | Write enable per lane (bit 0 lane A, bit 1 lane B) |
| din_a | input | W | Lane A input word |
| din_b | input | W | Lane B input word |
| dout_a | output | W | Lane A delayed word |
| dout_b | output | W | Lane B delayed word |

## Verification
A length load and a write enable on the same lane can arrive in the same clock. The design must then clear the counter and drop the word, rather than store it. The bench provokes this at the start of every scenario by raising the load strobe together with the enables. In the dual arrangement it does this separately for lane A and lane B. The bench judges the result in two ways:
- the lane's output must keep its earlier value through that cycle;
- the delay counted afterwards must match the newly loaded length measured from the next enabled word.

A stored word, or a counter that kept advancing, would shift every later comparison by one.

// File: rtl/lb_pkg.sv
`timescale 1ns/1ps
package lb_pkg;
    typedef enum logic [1:0] {
        ARR_DUAL     = 2'b00,
        ARR_TRIPLE   = 2'b01,
        ARR_DEEP     = 2'b10,
        ARR_DUAL_ALT = 2'b11
    } arr_e;
endpackage

// File: rtl/lb_addr_ctr.sv
`timescale 1ns/1ps
module lb_addr_ctr #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] ptr
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == limit) ? '0 : ptr + ONE;
        end
    end
endmodule

// File: rtl/lb_ram.sv
`timescale 1ns/1ps
module lb_ram #(
    parameter int DEPTH = 4096,
    parameter int W     = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [W-1:0]             wdata,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    // Storage: the new word replaces the old one at the same address.
    always_ff @(posedge clk) begin
        if (en) begin
            mem[addr] <= wdata;
        end
    end

    // Read port: returns the word that was there before this edge's write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/lb_line_delay.sv
`timescale 1ns/1ps
module lb_line_delay
    import lb_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int W     = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             mode,
    input  logic [$clog2(DEPTH):0] len_in,
    input  logic [1:0]             len_load,
    input  logic [1:0]             wr_en,
    input  logic [W-1:0]           din_a,
    input  logic [W-1:0]           din_b,
    output logic [W-1:0]           dout_a,
    output logic [W-1:0]           dout_b
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   ONE_L = (AW+1)'(1);
    localparam logic [AW-1:0] ONE_S = AW'(1);

    arr_e          arr;
    logic [AW:0]   len_a;
    logic [AW-1:0] len_b;
    logic [AW:0]   lim_a;
    logic [AW-1:0] lim_b;
    logic [AW:0]   ptr_a;
    logic [AW-1:0] ptr_b;
    logic          a_ld, a_adv, b_ld, b_adv;
    logic          ram_a_en, ram_b_en;
    logic [AW-1:0] ram_b_addr;
    logic [W-1:0]  ram_b_wd;
    logic [W-1:0]  q_a, q_b;
    logic          sel_q;

    assign arr   = arr_e'(mode);
    assign lim_b = len_b - ONE_S;

    // Arrangement decode: routes counters, enables and data to the two banks.
    always_comb begin
        a_ld       = len_load[0];
        a_adv      = wr_en[0] & ~len_load[0];
        b_ld       = 1'b0;
        b_adv      = 1'b0;
        ram_a_en   = a_adv;
        ram_b_en   = 1'b0;
        ram_b_addr = ptr_a[AW-1:0];
        ram_b_wd   = din_b;
        lim_a      = {1'b0, len_a[AW-1:0] - ONE_S};
        unique case (arr)
            ARR_DUAL, ARR_DUAL_ALT: begin
                b_ld       = len_load[1];
                b_adv      = wr_en[1] & ~len_load[1];
                ram_b_en   = b_adv;
                ram_b_addr = ptr_b;
            end
            ARR_TRIPLE: begin
                ram_b_en = a_adv;
            end
            ARR_DEEP: begin
                lim_a    = len_a - ONE_L;
                ram_a_en = a_adv & ~ptr_a[AW];
                ram_b_en = a_adv &  ptr_a[AW];
                ram_b_wd = din_a;
            end
        endcase
    end

    // Length registers and the bank-select of the last deep read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_a <= '0;
            len_b <= '0;
            sel_q <= 1'b0;
        end else begin
            if (len_load[0]) len_a <= len_in;
            if (b_ld)        len_b <= len_in[AW-1:0];
            if (a_adv)       sel_q <= ptr_a[AW];
        end
    end

    lb_addr_ctr #(.CW(AW+1)) u_ctr_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (a_ld),
        .step  (a_adv),
        .limit (lim_a),
        .ptr   (ptr_a)
    );

    lb_addr_ctr #(.CW(AW)) u_ctr_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (b_ld),
        .step  (b_adv),
        .limit (lim_b),
        .ptr   (ptr_b)
    );

    lb_ram #(.DEPTH(DEPTH), .W(W)) u_bank_a (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ram_a_en),
        .addr  (ptr_a[AW-1:0]),
        .wdata (din_a),
        .rdata (q_a)
    );

    lb_ram #(.DEPTH(DEPTH), .W(W)) u_bank_b (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ram_b_en),
        .addr  (ram_b_addr),
        .wdata (ram_b_wd),
        .rdata (q_b)
    );

    // Output selection.
    always_comb begin
        dout_a = ((arr == ARR_DEEP) && sel_q) ? q_b : q_a;
        dout_b = (arr == ARR_DEEP) ? '0 : q_b;
    end
endmodule

// File: rtl/lb_line_delay_chk.sv
`timescale 1ns/1ps
module lb_line_delay_chk #(
    parameter int AW = 12,
    parameter int W  = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic [1:0]    wr_en,
    input logic [1:0]    len_load,
    input logic [W-1:0]  dout_a,
    input logic [AW:0]   ptr_a,
    input logic [AW-1:0] ptr_b
);
    logic is_dual;
    assign is_dual = (mode == 2'b00) || (mode == 2'b11);

    // R5
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en[0] && !len_load[0]) |=> ($stable(ptr_a) && (!$stable(mode) || $stable(dout_a))));

    // R5
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_dual && (wr_en[1] || len_load[1])) |=> $stable(ptr_b));

    // R8
    a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len_load[0] |=> (ptr_a == '0));

    // R8
    b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_dual && len_load[1]) |=> (ptr_b == '0));

    // R2
    a_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && !len_load[0]) |=> ((ptr_a != $past(ptr_a)) || (ptr_a == '0)));
endmodule

bind lb_line_delay lb_line_delay_chk #(.AW(AW), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .wr_en    (wr_en),
    .len_load (len_load),
    .dout_a   (dout_a),
    .ptr_a    (ptr_a),
    .ptr_b    (ptr_b)
);

// File: tb/test_lb_line_delay.sv
`timescale 1ns/1ps
module test_lb_line_delay;
    localparam int DEPTH = 4096;
    localparam int W     = 12;
    localparam int AW    = $clog2(DEPTH);
    localparam int NSC   = 6;

    typedef struct packed {
        logic [1:0]  md;
        logic [12:0] la;
        logic [11:0] lb;
        logic [13:0] eff_a;
        logic [13:0] eff_b;
        logic [15:0] ncyc;
    } scen_t;

    // Scenario table: arrangement, loaded lengths, expected delays, run length.
    localparam scen_t SCEN [NSC] = '{
        '{2'b00, 13'd3,    12'd7, 14'd3,    14'd7, 16'd60},
        '{2'b00, 13'd1,    12'd1, 14'd1,    14'd1, 16'd40},
        '{2'b01, 13'd10,   12'd0, 14'd10,   14'd0, 16'd80},
        '{2'b10, 13'd5000, 12'd0, 14'd5000, 14'd0, 16'd10500},
        '{2'b00, 13'd0,    12'd2, 14'd4096, 14'd2, 16'd9000},
        '{2'b10, 13'd0,    12'd0, 14'd8192, 14'd0, 16'd17000}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic [AW:0]   len_in;
    logic [1:0]    len_load;
    logic [1:0]    wr_en;
    logic [W-1:0]  din_a, din_b;
    logic [W-1:0]  dout_a, dout_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lb_line_delay #(.DEPTH(DEPTH), .W(W)) i_lb_line_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .len_in   (len_in),
        .len_load (len_load),
        .wr_en    (wr_en),
        .din_a    (din_a),
        .din_b    (din_b),
        .dout_a   (dout_a),
        .dout_b   (dout_b)
    );

    function automatic logic [23:0] pat(int k, int salt);
        return 24'(k * 40503 + salt * 977 + 5);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: all requirements, actual=hung expected=complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'b00; len_in = '0; len_load = '0;
        wr_en = '0; din_a = '0; din_b = '0;
        repeat (3) tick();
        chk((dout_a == '0) && (dout_b == '0), "R1 in reset", {dout_b, dout_a}, 0);
        rst_n = 1'b1;
        tick();
        chk((dout_a == '0) && (dout_b == '0), "R1 after release", {dout_b, dout_a}, 0);

        for (int s = 0; s < NSC; s++) begin
            scen_t        sc;
            logic [W-1:0] pa, pb;
            int           ca, cb;
            bit           deep, trip;
            string        tag_a;
            sc   = SCEN[s];
            deep = (sc.md == 2'b10);
            trip = (sc.md == 2'b01);
            tag_a = deep ? ((sc.la == 0) ? "R4 deep" : "R7") :
                    ((sc.eff_a == 1) || (sc.eff_a == DEPTH)) ? "R4" : "R2";

            mode = sc.md; wr_en = '0; len_load = '0;
            tick();
            pa = dout_a; pb = dout_b;

            // Load with write enables raised in the same cycle: load wins.
            len_in = sc.la; len_load = 2'b01; wr_en = 2'b11;
            din_a = '1; din_b = '1;
            tick();
            chk(dout_a == pa, "R8 load A vs write", dout_a, pa);
            if (trip) chk(dout_b == pb, "R8 load triple vs write", dout_b, pb);
            if (deep) chk(dout_b == '0, "R7 dout_b quiet", dout_b, 0);
            pa = dout_a; pb = dout_b;

            if (!deep && !trip) begin
                len_in = {1'b0, sc.lb}; len_load = 2'b10; wr_en = 2'b10;
                tick();
                chk(dout_b == pb, "R8 load B vs write", dout_b, pb);
                chk(dout_a == pa, "R5 lane A idle", dout_a, pa);
                pa = dout_a; pb = dout_b;
            end

            len_load = '0; ca = 0; cb = 0;
            for (int c = 0; c < int'(sc.ncyc); c++) begin
                bit          ea, eb;
                logic [23:0] va, vb, ex;
                ea = (c % 5) != 3;
                eb = (c % 7) != 1;
                va = pat(ca, s);
                vb = pat(cb, s + 17);
                wr_en = {eb, ea};
                if (trip) begin
                    din_a = va[11:0]; din_b = va[23:12];
                end else if (deep) begin
                    din_a = va[11:0]; din_b = 12'(c);
                end else begin
                    din_a = va[11:0]; din_b = vb[11:0];
                end
                tick();
                if (ea) ca++;
                if (eb) cb++;
                if (trip) begin
                    if (!ea) begin
                        chk({dout_b, dout_a} == {pb, pa}, "R5 triple hold", {dout_b, dout_a}, {pb, pa});
                    end else if (ca > int'(sc.eff_a)) begin
                        ex = pat(ca - 1 - int'(sc.eff_a), s);
                        chk({dout_b, dout_a} == ex, "R6 three packed lanes", {dout_b, dout_a}, ex);
                    end
                end else begin
                    if (!ea) begin
                        chk(dout_a == pa, "R5 lane A hold", dout_a, pa);
                    end else if (ca > int'(sc.eff_a)) begin
                        ex = pat(ca - 1 - int'(sc.eff_a), s);
                        chk(dout_a == ex[11:0], tag_a, dout_a, ex[11:0]);
                    end
                    if (deep) begin
                        chk(dout_b == '0, "R7 dout_b quiet", dout_b, 0);
                    end else if (!eb) begin
                        chk(dout_b == pb, "R5 lane B hold", dout_b, pb);
                    end else if (cb > int'(sc.eff_b)) begin
                        ex = pat(cb - 1 - int'(sc.eff_b), s + 17);
                        chk(dout_b == ex[11:0], "R3 lane B delay", dout_b, ex[11:0]);
                    end
                end
                pa = dout_a; pb = dout_b;
            end
            wr_en = '0;
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule